// File: doc/BRIEF.md
# Suspend LED Blink Pattern Generator

This block drives a single indicator LED from an 8-bit configuration register. The three most significant bits of the register pick the pin behaviour: held high, held low, or a square wave at 4, 2, 1, 0.5 or 0.25 Hz. The remaining five bits are plain storage. They are read back unchanged, and a dedicated mode-only write leaves them intact.

All blink rates come from one free-running divider chain that runs off a slow reference clock. A prescaler turns the reference clock into an 8 Hz tick. A 5-bit phase counter then advances on each tick, and each of its bits is a 50% square wave at half the rate of the bit below it. A mode selects one bit of this counter. Because a mode change only moves the selection, the divider never restarts. The reference frequency is a parameter, so a bench can shrink one 4 Hz half-period to a few cycles.

Top module: `suspend_led_gen`

## Requirements
- R1: While reset is asserted, and after it is released with no write, the register reads 0x00 and the LED pin is high.
- R2: A cycle with `regWrEn` high loads all 8 bits of `wrData` into the register, and `rdData` shows the value from the next cycle on.
- R3: A cycle with `modeWrEn` high and `regWrEn` low replaces register bits 7:5 with `wrData[7:5]` and keeps bits 4:0. When both strobes are high, the full write of R2 wins.
- R4: Mode 000 in bits 7:5 holds the pin high on every cycle.
- R5: Mode 010 holds the pin low on every cycle.
- R6: With PRESCALE = REF_HZ/8 reference cycles per tick, mode 101 toggles the pin every PRESCALE cycles (4 Hz), mode 011 every 2·PRESCALE (2 Hz), mode 100 every 4·PRESCALE (1 Hz) and mode 001 every 8·PRESCALE (0.5 Hz).
- R7: Modes 110 and 111 both toggle the pin every 16·PRESCALE cycles (0.25 Hz).
- R8: Each pulsing mode has a 50% duty cycle. After n clock edges since reset, the pin equals bit k of floor(n/PRESCALE) mod 32, where k is 0, 1, 2, 3 or 4 for 4, 2, 1, 0.5 or 0.25 Hz.
- R9: The divider runs freely and is not reset by any write, so a new mode shows the phase of the shared divider in the cycle after the write.
- R10: A cycle with both strobes low leaves the register unchanged, whatever `wrData` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock at REF_HZ |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Full register write strobe |
| modeWrEn | input | 1 | Mode-field-only write strobe |
| wrData | input | 8 | Write data byte |
| rdData | output | 8 | Current register contents |
| ledOut | output | 1 | LED pin level |

## Verification
The in-module properties check the following on every cycle:
- the register holds when no strobe is active, and a mode-only write keeps the low five bits;
- the prescaler stays in range;
- the phase counter moves only on a tick, and by exactly one;
- the two constant modes hold the pin at their level.

The actual blink frequencies, the 50% duty, and the continuity of phase across mode changes need long windows measured against a cycle count from reset. Only the bench scenarios show these. They compare each sample with a divider model built from the edge count, and count transitions and high cycles over whole periods.

// File: rtl/susled_pkg.sv
package susled_pkg;
  localparam int REG_W    = 8;
  localparam int MODE_W   = 3;
  localparam int MODE_LSB = REG_W - MODE_W;
  localparam int PHASE_W  = 5;
  localparam int TAP_W    = $clog2(PHASE_W);

  typedef enum logic [MODE_W-1:0] {
    MODE_HIGH  = 3'b000,
    MODE_HALF  = 3'b001,
    MODE_LOW   = 3'b010,
    MODE_TWO   = 3'b011,
    MODE_ONE   = 3'b100,
    MODE_FOUR  = 3'b101,
    MODE_QTR_A = 3'b110,
    MODE_QTR_B = 3'b111
  } ledMode_e;

  typedef struct packed {
    logic             forceHigh;
    logic             forceLow;
    logic [TAP_W-1:0] tap;
  } ledSel_t;
endpackage

// File: rtl/susled_ctrl.sv
module susled_ctrl
  import susled_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic             modeWrEn,
  input  logic [REG_W-1:0] wrData,
  output logic [REG_W-1:0] regQ,
  output ledSel_t          sel
);
  ledMode_e mode;

  // Full write has priority over a mode-only write (R2, R3)
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      regQ <= '0;
    end else if (regWrEn) begin
      regQ <= wrData;
    end else if (modeWrEn) begin
      regQ <= {wrData[REG_W-1:MODE_LSB], regQ[MODE_LSB-1:0]};
    end
  end

  assign mode = ledMode_e'(regQ[REG_W-1:MODE_LSB]);

  // Decode the mode into strobes for the datapath; tap n is phase bit n
  always_comb begin
    sel = '{forceHigh: 1'b0, forceLow: 1'b0, tap: '0};
    unique case (mode)
      MODE_HIGH:  sel.forceHigh = 1'b1;
      MODE_LOW:   sel.forceLow  = 1'b1;
      MODE_FOUR:  sel.tap = TAP_W'(0);
      MODE_TWO:   sel.tap = TAP_W'(1);
      MODE_ONE:   sel.tap = TAP_W'(2);
      MODE_HALF:  sel.tap = TAP_W'(3);
      MODE_QTR_A,
      MODE_QTR_B: sel.tap = TAP_W'(4);
      default:    sel.forceHigh = 1'b1;
    endcase
  end

  p_full_load_r2: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |=> regQ == $past(wrData));

  p_low_bits_kept_r3: assert property (@(posedge clk) disable iff (!rstN)
    (modeWrEn && !regWrEn) |=> regQ[MODE_LSB-1:0] == $past(regQ[MODE_LSB-1:0]));

  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!regWrEn && !modeWrEn) |=> $stable(regQ));

  p_force_excl_r4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({sel.forceHigh, sel.forceLow}));
endmodule

// File: rtl/susled_datapath.sv
module susled_datapath
  import susled_pkg::*;
#(
  parameter int PRESCALE = 4096
) (
  input  logic    clk,
  input  logic    rstN,
  input  ledSel_t sel,
  output logic    ledOut
);
  localparam int CNT_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(PRESCALE - 1);

  logic [CNT_W-1:0]   cntQ;
  logic [PHASE_W-1:0] phaseQ;
  logic               tick;

  assign tick = (cntQ == CNT_LAST);

  // Free-running prescaler and phase counter, never touched by writes (R9)
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ   <= '0;
      phaseQ <= '0;
    end else if (tick) begin
      cntQ   <= '0;
      phaseQ <= phaseQ + 1'b1;
    end else begin
      cntQ   <= cntQ + 1'b1;
    end
  end

  always_comb begin
    if (sel.forceHigh)     ledOut = 1'b1;
    else if (sel.forceLow) ledOut = 1'b0;
    else                   ledOut = phaseQ[sel.tap];
  end

  p_cnt_bound_r9: assert property (@(posedge clk) disable iff (!rstN)
    cntQ <= CNT_LAST);

  p_phase_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    !tick |=> $stable(phaseQ));

  p_phase_step_r8: assert property (@(posedge clk) disable iff (!rstN)
    tick |=> phaseQ == PHASE_W'($past(phaseQ) + 1'b1));
endmodule

// File: rtl/suspend_led_gen.sv
module suspend_led_gen
  import susled_pkg::*;
#(
  parameter int REF_HZ  = 32768,
  parameter int FAST_HZ = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic             modeWrEn,
  input  logic [REG_W-1:0] wrData,
  output logic [REG_W-1:0] rdData,
  output logic             ledOut
);
  localparam int PRESCALE = REF_HZ / (2 * FAST_HZ);

  ledSel_t sel;

  susled_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .regWrEn  (regWrEn),
    .modeWrEn (modeWrEn),
    .wrData   (wrData),
    .regQ     (rdData),
    .sel      (sel)
  );

  susled_datapath #(.PRESCALE(PRESCALE)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .sel    (sel),
    .ledOut (ledOut)
  );

  p_const_high_r4: assert property (@(posedge clk) disable iff (!rstN)
    (rdData[REG_W-1:MODE_LSB] == MODE_HIGH) |-> ledOut);

  p_const_low_r5: assert property (@(posedge clk) disable iff (!rstN)
    (rdData[REG_W-1:MODE_LSB] == MODE_LOW) |-> !ledOut);
endmodule

// File: tb/tb_suspend_led_gen.sv
`timescale 1ns/1ps
module tb_suspend_led_gen;
  localparam int REF_HZ = 80;
  localparam int PRE    = REF_HZ / 8;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       regWrEn = 1'b0;
  logic       modeWrEn = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic [7:0] rdData;
  logic       ledOut;

  int   checks = 0;
  int   errors = 0;
  int   edgeCount = 0;
  logic [7:0] model = 8'h00;
  bit   done = 1'b0;

  always #4 clk = ~clk;

  always @(posedge clk) if (rstN) edgeCount <= edgeCount + 1;

  suspend_led_gen #(.REF_HZ(REF_HZ)) dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .modeWrEn(modeWrEn),
    .wrData(wrData), .rdData(rdData), .ledOut(ledOut)
  );

  function automatic logic expPin(logic [2:0] m, int ec);
    int ph = (ec / PRE) % 32;
    case (m)
      3'b000:         return 1'b1;
      3'b010:         return 1'b0;
      3'b101:         return logic'(ph & 1);
      3'b011:         return logic'((ph >> 1) & 1);
      3'b100:         return logic'((ph >> 2) & 1);
      3'b001:         return logic'((ph >> 3) & 1);
      default:        return logic'((ph >> 4) & 1);
    endcase
  endfunction

  function automatic string reqFor(logic [2:0] m);
    case (m)
      3'b000:  return "R4";
      3'b010:  return "R5";
      3'b110,
      3'b111:  return "R7 R8 R9";
      default: return "R6 R8 R9";
    endcase
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at edge %0d", req, act, exp, edgeCount);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    check(reqFor(model[7:5]), ledOut, expPin(model[7:5], edgeCount));
    check("R2 R3 R10 rdData", rdData, model);
  endtask

  task automatic doWrite(bit full, bit modeOnly, logic [7:0] d);
    regWrEn = full; modeWrEn = modeOnly; wrData = d;
    if (full) model = d;
    else if (modeOnly) model = {d[7:5], model[4:0]};
    tick();
    regWrEn = 1'b0; modeWrEn = 1'b0; wrData = 8'($urandom_range(0, 255));
  endtask

  // Count transitions over a window of 640 cycles: expected 640/(PRE*2^k)
  task automatic rateCheck(logic [2:0] m, int expToggles, string req);
    int toggles = 0;
    logic prev;
    doWrite(1'b0, 1'b1, {m, 5'b0});
    prev = ledOut;
    for (int i = 0; i < 64 * PRE; i++) begin
      tick();
      if (ledOut != prev) toggles++;
      prev = ledOut;
    end
    check(req, toggles, expToggles);
  endtask

  initial begin
    int highs;
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    check("R1 pin in reset", ledOut, 1);
    check("R1 reg in reset", rdData, 0);
    rstN = 1'b1;
    tick();
    check("R1 pin after reset", ledOut, 1);
    for (int i = 0; i < 20; i++) tick();

    // R3 directed: mode write keeps low bits, both strobes -> full write wins
    doWrite(1'b1, 1'b0, 8'h1F);
    doWrite(1'b0, 1'b1, 8'h40);
    check("R3 mode-only write", rdData, 8'h5F);
    doWrite(1'b1, 1'b1, 8'hA3);
    check("R3 both strobes", rdData, 8'hA3);
    // R10: data moves with no strobe
    wrData = 8'hFF; tick(); tick();
    check("R10 idle hold", rdData, 8'hA3);

    // R6 / R7 rates
    rateCheck(3'b101, 64, "R6 4Hz");
    rateCheck(3'b011, 32, "R6 2Hz");
    rateCheck(3'b100, 16, "R6 1Hz");
    rateCheck(3'b001,  8, "R6 0.5Hz");
    rateCheck(3'b110,  4, "R7 mode 110");
    rateCheck(3'b111,  4, "R7 mode 111");

    // R8 duty: 320 cycles of mode 110 give 160 high cycles
    doWrite(1'b0, 1'b1, 8'hC0);
    highs = 0;
    for (int i = 0; i < 32 * PRE; i++) begin
      tick();
      if (ledOut) highs++;
    end
    check("R8 duty", highs, 16 * PRE);

    // R9: change rate mid-phase, pin keeps the shared divider phase
    for (int i = 0; i < PRE / 2 + 3; i++) tick();
    doWrite(1'b0, 1'b1, 8'h60);
    doWrite(1'b0, 1'b1, 8'hA0);

    // R4 / R5 constant levels
    doWrite(1'b0, 1'b1, 8'h00);
    for (int i = 0; i < 4 * PRE; i++) tick();
    doWrite(1'b0, 1'b1, 8'h40);
    for (int i = 0; i < 4 * PRE; i++) tick();

    // Constrained random mix
    for (int n = 0; n < 300; n++) begin
      int op = $urandom_range(0, 3);
      doWrite(op[0], op[1], 8'($urandom_range(0, 255)));
      for (int w = 0; w < $urandom_range(1, 30); w++) tick();
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule